// File: doc/BRIEF.md
# Two-Stage Address Chip-Select Decoder

This block sits between a processor's 16-bit address bus and a set of external devices. It turns the address and an address-valid qualifier into active-low chip selects for a fixed memory map. The outputs are purely combinational. A first three-bit stage splits the 64 KB space into eight 8 KB blocks. A second three-bit stage is enabled by one of those blocks and splits it into eight 1 KB sub-blocks for the small devices.

The map holds five devices. A 16 KB RAM is selected from two adjacent 8 KB blocks that are merged by a negative-logic OR. A 4 KB ROM owns a whole 8 KB block. A 1 KB ROM, a 4-byte converter port and a 2-byte display port each take one 1 KB sub-block. Address bits below the decoded ones are never examined, so every device appears at aliased addresses. A separate active-high flag reports a valid access that selects no device.

Top module: `memmap_cs_decoder`

## Requirements
- R1: While `addr_valid_i` is 0, all five selects are 1 and `unmapped_o` is 0, whatever the address.
- R2: `rom_big_cs_n` is 0 exactly when valid and A15..A13 = 3'b001 ($2000-$3FFF). The 4 KB device is therefore seen twice in that range.
- R3: `ram_cs_n` is 0 exactly when valid and A15..A13 is 3'b010 or 3'b011 ($4000-$7FFF).
- R4: `rom_small_cs_n` is 0 exactly when valid, A15..A13 = 3'b100 and A12..A10 = 3'b000 ($8000-$83FF).
- R5: `adc_cs_n` is 0 exactly when valid, A15..A13 = 3'b100 and A12..A10 = 3'b001 ($8400-$87FF).
- R6: `lcd_cs_n` is 0 exactly when valid, A15..A13 = 3'b100 and A12..A10 = 3'b010 ($8800-$8BFF).
- R7: `unmapped_o` is 1 exactly when valid and no select is 0. This covers $0000-$1FFF, $8C00-$9FFF and $A000-$FFFF.
- R8: At most one of the five selects is 0 for any input.
- R9: Undecoded bits have no effect. Changing A9..A0 inside the $8000-$9FFF block, or A12..A0 anywhere else, never changes any output. For example, the converter register at offset n answers at every address in $8400-$87FF whose A1..A0 equal n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address, bit 15 most significant |
| addr_valid_i | input | 1 | High while the address is valid |
| ram_cs_n | output | 1 | 16 KB RAM select, active low |
| rom_big_cs_n | output | 1 | 4 KB ROM select, active low |
| rom_small_cs_n | output | 1 | 1 KB ROM select, active low |
| adc_cs_n | output | 1 | Converter port select, active low |
| lcd_cs_n | output | 1 | Display port select, active low |
| unmapped_o | output | 1 | Valid access that hits no device |

## Verification
Two outputs can react to the same address: the unmapped flag and a device select. The two first-stage outputs that both drive the RAM select are also a pair to watch. The bench drives every one of the 65536 addresses with valid high and a strided subset with valid low. It crosses the edges $1FFF/$2000, $7FFF/$8000 and $8BFF/$8C00. At each address it compares every output with a range test that it computes itself, and it requires that exactly one of "some select low" and "unmapped" holds whenever the access is valid. A separate pass flips the undecoded bits and requires the outputs not to change.

// File: rtl/memmap_cs_pkg.sv
package memmap_cs_pkg;
  localparam int ADDR_W   = 16;
  localparam int STAGE_W  = 3;
  localparam int STAGE_N  = 1 << STAGE_W;
  localparam int BLK_LSB  = ADDR_W - STAGE_W;
  localparam int SUB_LSB  = BLK_LSB - STAGE_W;

  // block codes on A15..A13
  localparam int ROM_BIG_BLK = 1;
  localparam int RAM_BLK_LO  = 2;
  localparam int SUB_BLK     = 4;
  // sub-block codes on A12..A10
  localparam int ROM_SMALL_SUB = 0;
  localparam int ADC_SUB       = 1;
  localparam int LCD_SUB       = 2;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [STAGE_W-1:0] code_t;

  function automatic code_t blk_code(addr_t a);
    return a[ADDR_W-1:BLK_LSB];
  endfunction

  function automatic code_t sub_code(addr_t a);
    return a[BLK_LSB-1:SUB_LSB];
  endfunction
endpackage

// File: rtl/onehot_low_decoder.sv
module onehot_low_decoder #(
  parameter int CODE_W = 3,
  localparam int OUT_N = 1 << CODE_W
) (
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_N-1:0]  sel_n_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_out
    assign sel_n_o[k] = !(en_i && (code_i == CODE_W'(k)));
  end

  // R8: a decoder never drives two of its outputs low
  always_comb begin
    dec_onehot_chk: assert ($countones(~sel_n_o) <= 1);
  end
endmodule

// File: rtl/memmap_cs_decoder.sv
module memmap_cs_decoder
  import memmap_cs_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        addr_valid_i,
  output logic        ram_cs_n,
  output logic        rom_big_cs_n,
  output logic        rom_small_cs_n,
  output logic        adc_cs_n,
  output logic        lcd_cs_n,
  output logic        unmapped_o
);
  logic [STAGE_N-1:0] blk_n;
  logic [STAGE_N-1:0] sub_n;
  logic               sub_en;
  logic [4:0]         dev_n;
  logic               unused_low;

  assign unused_low = ^addr_i[SUB_LSB-1:0];

  onehot_low_decoder #(.CODE_W(STAGE_W)) u_blk (
    .en_i   (addr_valid_i),
    .code_i (blk_code(addr_i)),
    .sel_n_o(blk_n)
  );

  assign sub_en = !blk_n[SUB_BLK];

  onehot_low_decoder #(.CODE_W(STAGE_W)) u_sub (
    .en_i   (sub_en),
    .code_i (sub_code(addr_i)),
    .sel_n_o(sub_n)
  );

  // negative-logic OR of two adjacent 8 KB blocks
  assign ram_cs_n       = blk_n[RAM_BLK_LO] & blk_n[RAM_BLK_LO+1];
  assign rom_big_cs_n   = blk_n[ROM_BIG_BLK];
  assign rom_small_cs_n = sub_n[ROM_SMALL_SUB];
  assign adc_cs_n       = sub_n[ADC_SUB];
  assign lcd_cs_n       = sub_n[LCD_SUB];

  assign dev_n      = {ram_cs_n, rom_big_cs_n, rom_small_cs_n, adc_cs_n, lcd_cs_n};
  assign unmapped_o = addr_valid_i && (&dev_n);

  always_comb begin
    // R1
    idle_quiet_chk: assert (addr_valid_i || ((&dev_n) && !unmapped_o));
    // R8
    one_select_chk: assert ($countones(~dev_n) <= 1);
    // R3
    ram_range_chk: assert (ram_cs_n ==
      !(addr_valid_i && addr_i >= 16'h4000 && addr_i <= 16'h7FFF));
    // R4
    sub_gate_chk: assert (!sub_en || (addr_i[15:13] == 3'b100 && $countones(~sub_n) == 1));
    // R7
    miss_excl_chk: assert (!addr_valid_i || (unmapped_o != ($countones(~dev_n) == 1)));
  end
endmodule

// File: tb/sim_memmap_cs_decoder.sv
module sim_memmap_cs_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] addr;
  logic        valid;
  logic ram_n, rbig_n, rsm_n, adc_n, lcd_n, miss;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  memmap_cs_decoder u0 (
    .addr_i(addr), .addr_valid_i(valid),
    .ram_cs_n(ram_n), .rom_big_cs_n(rbig_n), .rom_small_cs_n(rsm_n),
    .adc_cs_n(adc_n), .lcd_cs_n(lcd_n), .unmapped_o(miss)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s addr=%h valid=%0d got=%0d exp=%0d", tag, addr, valid, got, exp);
    end
  endtask

  task automatic apply(int a, bit v);
    @(negedge clk);
    addr  = 16'(a);
    valid = v;
    #1;
  endtask

  task automatic check_map(int a, bit v);
    int blk = a / 8192;
    int sub = (a % 8192) / 1024;
    bit e_ram = v && a >= 16384 && a < 32768;
    bit e_big = v && blk == 1;
    bit e_sm  = v && blk == 4 && sub == 0;
    bit e_adc = v && blk == 4 && sub == 1;
    bit e_lcd = v && blk == 4 && sub == 2;
    bit e_any = e_ram | e_big | e_sm | e_adc | e_lcd;
    int lows  = int'(!ram_n) + int'(!rbig_n) + int'(!rsm_n) + int'(!adc_n) + int'(!lcd_n);
    chk("R3 ram", ram_n, !e_ram);
    chk("R2 rom_big", rbig_n, !e_big);
    chk("R4 rom_small", rsm_n, !e_sm);
    chk("R5 adc", adc_n, !e_adc);
    chk("R6 lcd", lcd_n, !e_lcd);
    chk("R7 unmapped", miss, v && !e_any);
    chk("R8 at most one", int'(lows <= 1), 1);
    if (!v) chk("R1 idle", {ram_n, rbig_n, rsm_n, adc_n, lcd_n, miss}, 6'b111110);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] ref_out;
    addr = '0; valid = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset / idle state: R1
    apply(16'h4000, 0);
    chk("R1 reset idle", {ram_n, rbig_n, rsm_n, adc_n, lcd_n, miss}, 6'b111110);
    // R1: valid low sweep, strided
    for (int a = 0; a < 65536; a += 16) begin
      apply(a + (a / 16) % 16, 0);
      check_map(a + (a / 16) % 16, 0);
    end
    // full valid sweep: R2..R8
    for (int a = 0; a < 65536; a++) begin
      apply(a, 1);
      check_map(a, 1);
    end
    // R9: flip undecoded bits, outputs must not move
    for (int b = 0; b < 8; b++) begin
      int base = b * 8192 + 1024 * (b == 4 ? 1 : 0) + 2;
      apply(base, 1);
      ref_out = {ram_n, rbig_n, rsm_n, adc_n, lcd_n, miss};
      for (int k = 1; k < 24; k++) begin
        int msk = (b == 4) ? 1023 : 8191;
        int alt = (base & ~msk) | ((base ^ (k * 37 + k * k * 113)) & msk);
        apply(alt, 1);
        chk("R9 alias", {ram_n, rbig_n, rsm_n, adc_n, lcd_n, miss}, ref_out);
      end
    end
    // R9 / R5: converter offset 3 answers at $87FF as well as $8403
    apply(16'h8403, 1);
    chk("R5 adc offset base", adc_n, 0);
    apply(16'h87FF, 1);
    chk("R9 adc alias top", adc_n, 0);
    apply(16'h8C00, 1);
    chk("R7 just past lcd", miss, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule